// File: doc/BRIEF.md
# Lockable pin configuration register bank

This block holds one 32-bit configuration word per pin and exposes every field of those words as parallel outputs for the pad ring and the function multiplexer. Software reaches the bank through a word-addressed register port. A request is a valid/ready handshake. A read returns its data on a response channel that also uses valid/ready, and that channel can push back on the request side.

Each pin word can be written on its own, with byte strobes. Two broadcast registers let a single access load the same 16-bit value into the lower halves of up to sixteen pin words. One register serves pins 0 to 15 and the other serves pins 16 to 31. Each pin word has its own lock bit. Once the lock bit is set, the lower half of that word is frozen against every kind of write until reset. The interrupt-configuration nibble stays writable.

Back-pressure works as follows. A write completes when it is accepted and produces no response. A read is accepted and its response is valid in the next cycle. That response is held, with stable data, until `rsp_ready` is seen high. While a response is waiting and `rsp_ready` is low, `req_ready` is low.

Top module: `pin_cfg_bank`

## Requirements
- R1: After reset every pin word reads 0x00000742. That value means mux field = 7, pull enable = 1, drive strength = 1, and lock, pull select, slew, passive filter, open drain and interrupt config all 0.
- R2: A request at word address n below 32 with the write flag set updates pin word n. Byte lane k (bits 8k+7..8k) is written only when strobe bit k is set. Bits outside the implemented set 0x000F87F7 always read 0, and this includes bit 24.
- R3: A read accepted in cycle t gives `rsp_valid` = 1 from cycle t+1. `rsp_valid` and `rsp_rdata` then stay unchanged until a cycle in which `rsp_ready` is 1. While a response waits with `rsp_ready` low, `req_ready` is 0.
- R4: When bit 15 (lock) of a pin word is 1, bits [15:0] of that word ignore all writes until reset. The lock bit cannot be cleared by a write.
- R5: Bits [19:16] (interrupt config) remain writable through a direct write on byte lane 2, even when the word is locked.
- R6: A full write to word address 0x20 (broadcast low) copies data bits [15:0], masked to the implemented bits, into bits [15:0] of pin word i for every i in 0..15 whose enable bit [16+i] is set.
- R7: A full write to word address 0x21 (broadcast high) does the same for pin word 16+i, using enable bit [16+i].
- R8: A broadcast write leaves locked pin words unchanged and still updates the unlocked pins it selects in the same access.
- R9: A broadcast write whose four strobe bits are not all 1 has no effect on any pin word.
- R10: Reads of the broadcast registers, and of any address not holding a pin word, return 0. Writes to addresses not holding a pin word or a broadcast register change no pin word.
- R11: `dig_disable_o[p]` is 1 exactly when the mux field of pin p is 0. `gpio_sel_o[p]` is 1 exactly when it is 1.
- R12: The per-pin outputs carry the current field values: pull select bit 0, pull enable bit 1, slew bit 2, passive filter bit 4, open drain bit 5, drive bit 6, mux bits [10:8], lock bit 15, interrupt config bits [19:16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bank can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (6) | Word address |
| req_wdata | input | 32 | Write data |
| req_strb | input | 4 | Byte strobes for writes |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Requester takes read data |
| rsp_rdata | output | 32 | Read data |
| pull_sel_o | output | NUM_PINS | Pull direction per pin |
| pull_en_o | output | NUM_PINS | Pull enable per pin |
| slew_o | output | NUM_PINS | Slow slew per pin |
| pfilt_o | output | NUM_PINS | Passive filter enable per pin |
| odrain_o | output | NUM_PINS | Open drain enable per pin |
| drive_o | output | NUM_PINS | High drive per pin |
| mux_o | output | 3*NUM_PINS | Mux field, pin p at [3p+2:3p] |
| lock_o | output | NUM_PINS | Lock state per pin |
| irq_cfg_o | output | 4*NUM_PINS | Interrupt config, pin p at [4p+3:4p] |
| dig_disable_o | output | NUM_PINS | Pin digitally disabled (mux 0) |
| gpio_sel_o | output | NUM_PINS | General-purpose I/O selected (mux 1) |

## Verification
A corrupted pin word appears on its field outputs one cycle after the write that caused it. The same corruption appears in the read response one cycle after a read is accepted. A lock that fails to hold shows up as a change on `mux_o` or `lock_o` of a locked pin in the cycle after the offending access. A broadcast decode error shows as the wrong set of pins updating, so the bench reads back neighbours of each selected pin as well as the selected pins. A response-channel fault is visible in the first cycle that `rsp_ready` is held low.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned HALF_W  = 16;
  localparam int unsigned GROUP   = 16;
  localparam int unsigned IRQ_W   = 4;
  localparam int unsigned LOCK_B  = 15;
  // word addresses of the two broadcast registers
  localparam int unsigned BC_LO_WORD = 'h20;
  localparam int unsigned BC_HI_WORD = 'h21;
  localparam logic [WORD_W-1:0] PIN_RESET = 32'h0000_0742;
  localparam logic [HALF_W-1:0] LO_MASK   = 16'h87F7;

  function automatic logic [HALF_W-1:0] lane_merge(
    input logic [HALF_W-1:0] cur,
    input logic [HALF_W-1:0] nxt,
    input logic [1:0]        strb
  );
    logic [HALF_W-1:0] r;
    r = cur;
    if (strb[0]) r[7:0]  = nxt[7:0];
    if (strb[1]) r[15:8] = nxt[15:8];
    return r & LO_MASK;
  endfunction
endpackage

// File: rtl/pcfg_decode.sv
module pcfg_decode
  import pcfg_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned ADDR_W   = 6,
  localparam int unsigned IDX_W   = $clog2(NUM_PINS)
) (
  input  logic                wr_acc,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [3:0]          strb,
  input  logic [HALF_W-1:0]   bc_en,
  output logic [NUM_PINS-1:0] dir_we,
  output logic [NUM_PINS-1:0] bc_we,
  output logic [IDX_W-1:0]    rd_idx,
  output logic                rd_hit
);
  logic full, lo_hit, hi_hit;

  assign full   = &strb;
  assign lo_hit = wr_acc && full && (addr == ADDR_W'(BC_LO_WORD));
  assign hi_hit = wr_acc && full && (addr == ADDR_W'(BC_HI_WORD));
  assign rd_hit = (addr < ADDR_W'(NUM_PINS));
  assign rd_idx = addr[IDX_W-1:0];

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_sel
    assign dir_we[p] = wr_acc && (addr == ADDR_W'(p));
    if (p < GROUP) begin : g_lo
      assign bc_we[p] = lo_hit && bc_en[p];
    end else if (p < 2*GROUP) begin : g_hi
      assign bc_we[p] = hi_hit && bc_en[p-GROUP];
    end else begin : g_none
      assign bc_we[p] = 1'b0;
    end
  end
endmodule

// File: rtl/pcfg_pin_reg.sv
module pcfg_pin_reg
  import pcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_we,
  input  logic [2:0]        strb,
  input  logic [19:0]       wdata,
  input  logic              bc_we,
  input  logic [HALF_W-1:0] bc_data,
  output logic [WORD_W-1:0] word
);
  logic [HALF_W-1:0] lo_q;
  logic [IRQ_W-1:0]  irq_q;
  logic              frozen;

  assign frozen = lo_q[LOCK_B];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q  <= PIN_RESET[HALF_W-1:0];
      irq_q <= PIN_RESET[HALF_W+IRQ_W-1:HALF_W];
    end else begin
      if (!frozen) begin
        if (bc_we)
          lo_q <= bc_data & LO_MASK;
        else if (dir_we)
          lo_q <= lane_merge(lo_q, wdata[HALF_W-1:0], strb[1:0]);
      end
      if (dir_we && strb[2])
        irq_q <= wdata[HALF_W+IRQ_W-1:HALF_W];
    end
  end

  assign word = {{(WORD_W-HALF_W-IRQ_W){1'b0}}, irq_q, lo_q};
endmodule

// File: rtl/pcfg_rdmux.sv
module pcfg_rdmux
  import pcfg_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  localparam int unsigned IDX_W   = $clog2(NUM_PINS)
) (
  input  logic [NUM_PINS-1:0][WORD_W-1:0] words,
  input  logic [IDX_W-1:0]                idx,
  input  logic                            hit,
  output logic [WORD_W-1:0]               rdata
);
  always_comb begin
    rdata = '0;
    if (hit) rdata = words[idx];
  end
endmodule

// File: rtl/pin_cfg_bank.sv
module pin_cfg_bank
  import pcfg_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned ADDR_W   = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [31:0]           req_wdata,
  input  logic [3:0]            req_strb,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [31:0]           rsp_rdata,
  output logic [NUM_PINS-1:0]   pull_sel_o,
  output logic [NUM_PINS-1:0]   pull_en_o,
  output logic [NUM_PINS-1:0]   slew_o,
  output logic [NUM_PINS-1:0]   pfilt_o,
  output logic [NUM_PINS-1:0]   odrain_o,
  output logic [NUM_PINS-1:0]   drive_o,
  output logic [3*NUM_PINS-1:0] mux_o,
  output logic [NUM_PINS-1:0]   lock_o,
  output logic [4*NUM_PINS-1:0] irq_cfg_o,
  output logic [NUM_PINS-1:0]   dig_disable_o,
  output logic [NUM_PINS-1:0]   gpio_sel_o
);
  localparam int unsigned IDX_W = $clog2(NUM_PINS);

  logic                            acc, wr_acc, rd_acc;
  logic [NUM_PINS-1:0]             dir_we, bc_we;
  logic [IDX_W-1:0]                rd_idx;
  logic                            rd_hit;
  logic [NUM_PINS-1:0][WORD_W-1:0] words;
  logic [WORD_W-1:0]               rd_word;

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign wr_acc    = acc && req_write;
  assign rd_acc    = acc && !req_write;

  pcfg_decode #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_dec (
    .wr_acc (wr_acc),
    .addr   (req_addr),
    .strb   (req_strb),
    .bc_en  (req_wdata[31:16]),
    .dir_we (dir_we),
    .bc_we  (bc_we),
    .rd_idx (rd_idx),
    .rd_hit (rd_hit)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    pcfg_pin_reg u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .dir_we  (dir_we[p]),
      .strb    (req_strb[2:0]),
      .wdata   (req_wdata[19:0]),
      .bc_we   (bc_we[p]),
      .bc_data (req_wdata[15:0]),
      .word    (words[p])
    );
    assign pull_sel_o[p]        = words[p][0];
    assign pull_en_o[p]         = words[p][1];
    assign slew_o[p]            = words[p][2];
    assign pfilt_o[p]           = words[p][4];
    assign odrain_o[p]          = words[p][5];
    assign drive_o[p]           = words[p][6];
    assign mux_o[3*p +: 3]      = words[p][10:8];
    assign lock_o[p]            = words[p][LOCK_B];
    assign irq_cfg_o[4*p +: 4]  = words[p][19:16];
    assign dig_disable_o[p]     = (words[p][10:8] == 3'd0);
    assign gpio_sel_o[p]        = (words[p][10:8] == 3'd1);
  end

  pcfg_rdmux #(.NUM_PINS(NUM_PINS)) u_rd (
    .words (words),
    .idx   (rd_idx),
    .hit   (rd_hit),
    .rdata (rd_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (rd_acc) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_word;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pin_cfg_bank_chk.sv
module pin_cfg_bank_chk #(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned ADDR_W   = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic                  req_write,
  input logic [ADDR_W-1:0]     req_addr,
  input logic                  rsp_valid,
  input logic                  rsp_ready,
  input logic [31:0]           rsp_rdata,
  input logic [NUM_PINS-1:0]   lock_o,
  input logic [3*NUM_PINS-1:0] mux_o
);
  logic [3*NUM_PINS-1:0] lk3;
  logic                  bc_read;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_lk
    assign lk3[3*p +: 3] = {3{lock_o[p]}};
  end

  assign bc_read = req_valid && req_ready && !req_write &&
                   (req_addr == ADDR_W'('h20) || req_addr == ADDR_W'('h21));

  // R4
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lock_o & $past(lock_o)) == $past(lock_o)));

  // R4
  locked_mux_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((mux_o ^ $past(mux_o)) & $past(lk3)) == '0));

  // R3
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R10
  bc_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bc_read |=> (rsp_valid && rsp_rdata == 32'd0));

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_rdata & ~32'h000F87F7) == 32'd0));
endmodule

bind pin_cfg_bank pin_cfg_bank_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_rdata (rsp_rdata),
  .lock_o    (lock_o),
  .mux_o     (mux_o)
);

// File: tb/tb_pin_cfg_bank.sv
module tb_pin_cfg_bank;
  localparam int NP = 32;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0] req_strb = '0;
  logic req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic [NP-1:0] pull_sel_o, pull_en_o, slew_o, pfilt_o, odrain_o, drive_o;
  logic [NP-1:0] lock_o, dig_disable_o, gpio_sel_o;
  logic [3*NP-1:0] mux_o;
  logic [4*NP-1:0] irq_cfg_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pin_cfg_bank #(.NUM_PINS(NP), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_strb(req_strb),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .pull_sel_o(pull_sel_o), .pull_en_o(pull_en_o), .slew_o(slew_o),
    .pfilt_o(pfilt_o), .odrain_o(odrain_o), .drive_o(drive_o),
    .mux_o(mux_o), .lock_o(lock_o), .irq_cfg_o(irq_cfg_o),
    .dig_disable_o(dig_disable_o), .gpio_sel_o(gpio_sel_o)
  );

  typedef struct packed {
    logic        rd;
    logic [5:0]  addr;
    logic [31:0] data;
    logic [3:0]  strb;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 6'h02, 32'h000A_0133, 4'hF, 32'h0, 8'd2},   // R2 full write pin 2
    '{1'b1, 6'h02, 32'h0,         4'h0, 32'h000A_0133, 8'd2},
    '{1'b0, 6'h03, 32'hFFFF_FFFF, 4'h1, 32'h0, 8'd2},   // R2 byte lane 0 only
    '{1'b1, 6'h03, 32'h0,         4'h0, 32'h0000_07F7, 8'd2},
    '{1'b0, 6'h20, 32'h0005_0261, 4'hF, 32'h0, 8'd6},   // R6 pins 0 and 2
    '{1'b1, 6'h00, 32'h0,         4'h0, 32'h0000_0261, 8'd6},
    '{1'b1, 6'h02, 32'h0,         4'h0, 32'h000A_0261, 8'd6},
    '{1'b1, 6'h01, 32'h0,         4'h0, 32'h0000_0742, 8'd6},
    '{1'b0, 6'h21, 32'h8001_0100, 4'hF, 32'h0, 8'd7},   // R7 pins 16 and 31
    '{1'b1, 6'h10, 32'h0,         4'h0, 32'h0000_0100, 8'd7},
    '{1'b1, 6'h1F, 32'h0,         4'h0, 32'h0000_0100, 8'd7},
    '{1'b1, 6'h11, 32'h0,         4'h0, 32'h0000_0742, 8'd7},
    '{1'b1, 6'h20, 32'h0,         4'h0, 32'h0, 8'd10},  // R10 broadcast reads
    '{1'b1, 6'h21, 32'h0,         4'h0, 32'h0, 8'd10},
    '{1'b1, 6'h30, 32'h0,         4'h0, 32'h0, 8'd10},
    '{1'b0, 6'h24, 32'hFFFF_FFFF, 4'hF, 32'h0, 8'd10},  // R10 unmapped write
    '{1'b1, 6'h00, 32'h0,         4'h0, 32'h0000_0261, 8'd10}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_strb = s;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_strb = 4'h0;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R12 reset state on field outputs
    check("R1 mux", 32'(mux_o[3*5 +: 3]), 32'd7);
    check("R1 pull_en", 32'(pull_en_o), 32'hFFFF_FFFF);
    check("R12 drive", 32'(drive_o), 32'hFFFF_FFFF);
    check("R1 lock", 32'(lock_o), 32'h0);
    check("R12 pull_sel/slew", 32'(pull_sel_o | slew_o | pfilt_o | odrain_o), 32'h0);
    check("R11 reset gpio/dis", 32'(gpio_sel_o | dig_disable_o), 32'h0);
    check("R3 rsp idle", 32'(rsp_valid), 32'd0);
    bus_rd(6'h05, rd);
    check("R1 read pin5", rd, 32'h0000_0742);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].rd) begin
        bus_rd(VEC[i].addr, rd);
        check($sformatf("table %0d R%0d", i, VEC[i].req), rd, VEC[i].exp);
      end else begin
        bus_wr(VEC[i].addr, VEC[i].data, VEC[i].strb);
      end
    end

    // R11 mux decode outputs, R12 field output
    bus_wr(6'h04, 32'h0000_0000, 4'h3);
    bus_wr(6'h05, 32'h0000_0100, 4'h3);
    @(negedge clk);
    check("R11 dig_disable pin4", 32'(dig_disable_o[4]), 32'd1);
    check("R11 gpio_sel pin5", 32'(gpio_sel_o[5]), 32'd1);
    check("R11 gpio_sel pin4", 32'(gpio_sel_o[4]), 32'd0);
    check("R12 pull_en pin4", 32'(pull_en_o[4]), 32'd0);

    // R4 lock freezes low half, R5 irq config stays writable
    bus_wr(6'h06, 32'h0000_8101, 4'h3);
    bus_wr(6'h06, 32'h0005_0702, 4'hF);
    bus_rd(6'h06, rd);
    check("R4 R5 locked pin6", rd, 32'h0005_8101);
    check("R4 lock_o pin6", 32'(lock_o[6]), 32'd1);
    check("R12 irq_cfg pin6", 32'(irq_cfg_o[4*6 +: 4]), 32'd5);
    bus_wr(6'h06, 32'h0000_0000, 4'h3);
    bus_rd(6'h06, rd);
    check("R4 lock not clearable", rd, 32'h0005_8101);

    // R8 broadcast skips locked pin only
    bus_wr(6'h20, 32'h00C0_0042, 4'hF);
    bus_rd(6'h06, rd);
    check("R8 locked pin6", rd, 32'h0005_8101);
    bus_rd(6'h07, rd);
    check("R8 unlocked pin7", rd, 32'h0000_0042);

    // R9 partial strobe broadcast ignored
    bus_wr(6'h20, 32'h0100_0000, 4'h7);
    bus_rd(6'h08, rd);
    check("R9 pin8", rd, 32'h0000_0742);

    // R3 back-pressure on the response channel
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 6'h07;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R3 rsp_valid", 32'(rsp_valid), 32'd1);
    check("R3 data", rsp_rdata, 32'h0000_0042);
    check("R3 req_ready low", 32'(req_ready), 32'd0);
    repeat (3) @(negedge clk);
    check("R3 held valid", 32'(rsp_valid), 32'd1);
    check("R3 held data", rsp_rdata, 32'h0000_0042);
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R3 released", 32'(rsp_valid), 32'd0);

    // R4 lock lasts until reset
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R4 lock cleared by reset", 32'(lock_o[6]), 32'd0);
    bus_rd(6'h06, rd);
    check("R1 pin6 after reset", rd, 32'h0000_0742);

    finish_run();
  end
endmodule